// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the bit engine of an SPI master. When enabled and idle, it takes one word from an external transmit FIFO and shifts it out on `mosi`, most significant bit first. At the same time it shifts `miso` into a receive word. Each completed receive word goes to an external receive FIFO. The FIFO storage and the register interface sit outside this block. The engine sees the transmit FIFO only through its empty flag, its head word and a pop strobe. It sees the receive FIFO only through its full flag, a data word and a push strobe.

`sck` is made from a half-period divisor. The configuration inputs set the idle level of `sck`, which `sck` edge moves output data, and whether input data is sampled in the middle or at the end of each bit. Word length is 8, 16 or 32 bits. An optional automatic slave-select drives an active-low select line. The line is low while the transmit FIFO holds data or a word is in flight.

Top module: `spi_shift_engine`

## Requirements
- R1: `wlen` selects the word length, which is captured when a word is loaded: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 is 32 bits, and the reserved code 2'b11 behaves as 8 bits. Data moves most significant bit first, and `rx_data` carries the received bits right-aligned with the unused upper bits zero.
- R2: Each half period of `sck` lasts `baud_div`+1 clock cycles, and a word of N bits produces exactly 2N `sck` transitions.
- R3: While no word is in flight, `sck` equals `cpol`: 0 gives an idle-low clock and 1 gives an idle-high clock.
- R4: The most significant bit appears on `mosi` when the word is loaded. Later bits change only on active-to-idle `sck` transitions when `cke`=1, and only on idle-to-active transitions when `cke`=0.
- R5: With `smp`=0, a bit is sampled in the middle of its output time. With `smp`=1, it is sampled one half period later, at the end of its output time. Counting the load edge as cycle 0, the last bit is sampled in cycle (`baud_div`+1)·(S+1), where S is 2N-2 for cke=1/smp=0, 2N-1 for cke=1/smp=1 and for cke=0/smp=0, and 2N for cke=0/smp=1.
- R6: While `en` is 0, no word is loaded. Clearing `en` during a word stops the word within one cycle, drops `busy` and returns `sck` to `cpol`.
- R7: With `auto_ss`=1 and `en`=1, `ss_n` is 0 while the transmit FIFO is non-empty or a word is in flight, and 1 otherwise. With `auto_ss`=0, `ss_n` stays 1.
- R8: `tx_pop` is a single-cycle strobe. It is raised only when `en` is 1, the transmit FIFO is non-empty and no word is in flight. The word on `tx_data` is loaded at that clock edge.
- R9: In the cycle the last bit is sampled, the word is pushed with `rx_push`. If `rx_full` is 1 in that cycle, the word is dropped instead: `rx_ovf` pulses for one cycle and `rx_push` stays low.
- R10: `busy` is high from the load edge until the final half period ends, for (`baud_div`+1)·L cycles, where L is 2N half periods, or 2N+1 for cke=0/smp=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| cpol | input | 1 | Idle level of `sck` |
| cke | input | 1 | 1: output changes on active-to-idle edge; 0: on idle-to-active edge |
| smp | input | 1 | 1: sample at end of bit; 0: sample in middle |
| wlen | input | 2 | Word-length code |
| baud_div | input | DIV_W | Half-period divisor value |
| auto_ss | input | 1 | Enable automatic slave-select |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_data | input | DATA_W | Transmit FIFO head word |
| tx_pop | output | 1 | Transmit FIFO pop strobe |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_data | output | DATA_W | Received word, valid with `rx_push` |
| rx_push | output | 1 | Receive FIFO push strobe |
| rx_ovf | output | 1 | Received word dropped because the receive FIFO was full |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Word in flight |

## Verification
With `smp`=1, sampling the incoming bit and presenting the next outgoing bit fall on the same `sck` edge and in the same clock cycle. The bench provokes this by looping `mosi` back to `miso` across every combination of polarity, edge, sample point and word length. It judges the result by requiring the received word to equal the transmitted word exactly, so a sample taken after the shift shows up as a displaced bit. The last sample and the overflow decision also coincide. Words are therefore also sent with `rx_full` held high, and the push and overflow strobes are each counted against the sample cycle the bench computes.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // word length code -> bit count (reserved code runs as 8 bits)
  function automatic int word_bits(input logic [1:0] code);
    case (code)
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 8;
    endcase
  endfunction

  // half periods per word: one extra idle half period when the
  // end-of-bit sample of the last bit falls past the final edge
  function automatic int half_total(input int n, input bit cke, input bit smp);
    return 2 * n + ((!cke && smp) ? 1 : 0);
  endfunction

  // does the end of half period h carry a sample
  function automatic bit sample_at(input int h, input int n, input bit cke, input bit smp);
    if (cke && !smp)      return (h % 2 == 0) && (h < 2 * n);
    else if (cke || !smp) return (h % 2 == 1);
    else                  return (h % 2 == 0) && (h >= 2) && (h <= 2 * n);
  endfunction

  // index of the half period that samples the final bit
  function automatic int last_sample(input int n, input bit cke, input bit smp);
    if (cke && !smp)      return 2 * n - 2;
    else if (cke || !smp) return 2 * n - 1;
    else                  return 2 * n;
  endfunction

  // does the end of half period h present the next output bit
  function automatic bit drive_at(input int h, input int n, input bit cke);
    if (cke) return (h % 2 == 1) && (h < 2 * n - 1);
    else     return (h % 2 == 0) && (h >= 2) && (h < 2 * n);
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift_ev,
  input  logic              sample_ev,
  input  logic              miso,
  input  int                nbits,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-2:0] rx_q;
  logic [DATA_W-1:0] rx_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
      rx_q <= '0;
    end else begin
      if (shift_ev)  tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (sample_ev) rx_q <= {rx_q[DATA_W-3:0], miso};
    end
  end

  always_comb begin
    case (nbits)
      16:      mosi = tx_q[15];
      32:      mosi = tx_q[DATA_W-1];
      default: mosi = tx_q[7];
    endcase
  end

  // the word includes the bit being sampled this cycle
  assign rx_raw = {rx_q, miso};

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      rx_word[i] = (i < nbits) ? rx_raw[i] : 1'b0;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              cke,
  input  logic              smp,
  input  logic [1:0]        wlen,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              auto_ss,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_push,
  output logic              rx_ovf,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n,
  output logic              busy
);
  localparam int HW = $clog2(2 * DATA_W + 2);

  logic          active_q, phase_q;
  logic [HW-1:0] h_q;
  logic [1:0]    code_q;

  // named internal events
  logic half_tick, run, load_ev, edge_ev, sample_ev, shift_ev, last_sample_ev, word_done;
  int   nbits, hcur;

  assign run     = active_q && en;
  assign load_ev = en && !active_q && !tx_empty;
  assign nbits   = word_bits(code_q);
  assign hcur    = int'(h_q);

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(baud_div), .tick(half_tick)
  );

  assign edge_ev        = half_tick && (hcur < 2 * nbits);
  assign sample_ev      = half_tick && sample_at(hcur, nbits, cke, smp);
  assign shift_ev       = half_tick && drive_at(hcur, nbits, cke);
  assign last_sample_ev = sample_ev && (hcur == last_sample(nbits, cke, smp));
  assign word_done      = half_tick && (hcur == half_total(nbits, cke, smp) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      h_q      <= '0;
      code_q   <= 2'b00;
    end else if (!en) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      h_q      <= '0;
    end else if (load_ev) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      h_q      <= '0;
      code_q   <= wlen;
    end else if (half_tick) begin
      if (edge_ev) phase_q <= !phase_q;
      if (word_done) begin
        active_q <= 1'b0;
        h_q      <= '0;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .load_word(tx_data),
    .shift_ev(shift_ev), .sample_ev(sample_ev), .miso(miso),
    .nbits(nbits), .mosi(mosi), .rx_word(rx_data)
  );

  assign tx_pop  = load_ev;
  assign rx_push = last_sample_ev && !rx_full;
  assign rx_ovf  = last_sample_ev && rx_full;
  assign sck     = cpol ^ phase_q;
  assign busy    = active_q;
  assign ss_n    = !(auto_ss && en && (active_q || !tx_empty));
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic auto_ss,
  input logic tx_pop,
  input logic rx_full,
  input logic rx_push,
  input logic rx_ovf,
  input logic sck,
  input logic ss_n,
  input logic busy,
  input logic tick
);
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  p_sck_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick) && $stable(cpol)) |-> $stable(sck));

  p_load_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy);

  p_pop_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop);

  p_push_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  p_ovf_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> rx_full);

  p_ovf_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> !rx_ovf);

  p_sample_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_ovf) |-> (busy && tick));

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  p_ss_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_ss && en && busy) |-> !ss_n);

  p_ss_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_ss |-> ss_n);
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .auto_ss(auto_ss),
  .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_ovf(rx_ovf),
  .sck(sck), .ss_n(ss_n), .busy(busy), .tick(half_tick)
);

// File: tb/spi_shift_engine_bench.sv
module spi_shift_engine_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, cpol = 1'b0, cke = 1'b0, smp = 1'b0, auto_ss = 1'b0;
  logic [1:0]  wlen = 2'b00;
  logic [8:0]  baud_div = '0;
  logic        tx_empty = 1'b1, rx_full = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_pop, rx_push, rx_ovf, sck, mosi, miso, ss_n, busy;
  logic [31:0] rx_data;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;
  assign miso = mosi;  // loopback

  spi_shift_engine u_spi_shift_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cke(cke), .smp(smp),
    .wlen(wlen), .baud_div(baud_div), .auto_ss(auto_ss), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full), .rx_data(rx_data),
    .rx_push(rx_push), .rx_ovf(rx_ovf), .sck(sck), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one word with full observation
  task automatic run_word(input bit p, input bit e, input bit s, input logic [1:0] code,
                          input int div, input logic [31:0] data, input bit full, input bit aut);
    int n, hs, hl, k, push_k, push_n, ovf_n, tog, mviol, ssviol;
    logic [31:0] got, expw;
    logic psck, pmosi;
    n  = (code == 2'b01) ? 16 : (code == 2'b10) ? 32 : 8;
    hs = e ? (s ? 2*n-1 : 2*n-2) : (s ? 2*n : 2*n-1);
    hl = 2*n + ((!e && s) ? 1 : 0);
    expw = (n == 32) ? data : (data & ((32'd1 << n) - 1));
    @(negedge clk);
    cpol = p; cke = e; smp = s; wlen = code; baud_div = 9'(div);
    rx_full = full; auto_ss = aut; tx_data = data; tx_empty = 1'b0;
    #1;
    chk(tx_pop == 1'b1, "R8 pop", tx_pop, 1);
    chk(sck == p, "R3 idle level", sck, p);
    chk(ss_n == !aut, "R7 ss before load", ss_n, !aut);
    psck = sck; pmosi = mosi;
    @(negedge clk);
    tx_empty = 1'b1;
    #1;
    chk(tx_pop == 1'b0, "R8 pop single", tx_pop, 0);
    k = 1; push_k = -1; push_n = 0; ovf_n = 0; tog = 0; mviol = 0; ssviol = 0; got = '0;
    forever begin
      if (rx_push) begin push_n++; push_k = k; got = rx_data; end
      if (rx_ovf)  begin ovf_n++;  push_k = k; end
      if (sck != psck) tog++;
      if (k >= 2 && mosi != pmosi && (sck == psck || sck != (e ? p : !p))) mviol++;
      if (busy && ss_n != !aut) ssviol++;
      psck = sck; pmosi = mosi;
      if (!busy || k > 20000) break;
      @(negedge clk); #1;
      k++;
    end
    chk(k - 1 == (div+1)*hl, "R10 busy length", k-1, (div+1)*hl);
    chk(tog == 2*n, "R2 sck transitions", tog, 2*n);
    chk(sck == p, "R3 idle after word", sck, p);
    chk(mviol == 0, "R4 mosi change edge", mviol, 0);
    chk(ssviol == 0, "R7 ss during word", ssviol, 0);
    chk(push_k == (div+1)*(hs+1), "R5 sample cycle", push_k, (div+1)*(hs+1));
    if (full) begin
      chk(ovf_n == 1 && push_n == 0, "R9 overflow drop", {ovf_n, push_n}, 1);
    end else begin
      chk(push_n == 1 && ovf_n == 0, "R9 push once", {ovf_n, push_n}, 1);
      chk(got == expw, "R1 loopback word", got, expw);
    end
    chk(ss_n == 1'b1, "R7 ss after word", ss_n, 1);
  endtask

  initial begin
    #(PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int idx = 0;
    #(PERIOD * 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && tx_pop == 0 && rx_push == 0 && rx_ovf == 0, "R10 reset state", busy, 0);
    chk(sck == 0 && ss_n == 1, "R3 reset sck", {sck, ss_n}, 1);

    // R6: no load while disabled
    tx_empty = 1'b0; auto_ss = 1'b1;
    repeat (4) begin
      @(negedge clk); #1;
      chk(tx_pop == 0 && busy == 0, "R6 disabled no load", {tx_pop, busy}, 0);
      chk(ss_n == 1, "R7 ss disabled", ss_n, 1);
    end
    tx_empty = 1'b1;
    en = 1'b1;

    // sweep over modes, lengths, divisors
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 2; p++)
          for (int d = 0; d < 3; d += 2) begin
            idx++;
            run_word(p[0], m[1], m[0], c[1:0], d,
                     (32'h9E3779B9 * idx) ^ 32'h5A5AC3C3, 1'b0, idx[0]);
          end

    // R9 overflow in each sample mode
    for (int m = 0; m < 4; m++)
      run_word(1'b0, m[1], m[0], 2'b00, 1, 32'h0000_00C5, 1'b1, 1'b1);

    // R1 extremes
    run_word(1'b0, 1'b1, 1'b0, 2'b10, 0, 32'h8000_0001, 1'b0, 1'b1);
    run_word(1'b1, 1'b0, 1'b1, 2'b01, 4, 32'hFFFF_0000, 1'b0, 1'b1);
    run_word(1'b0, 1'b0, 1'b0, 2'b11, 0, 32'h1234_56FF, 1'b0, 1'b0);

    // R6: disable mid word
    @(negedge clk);
    cpol = 1'b1; cke = 1'b1; smp = 1'b0; wlen = 2'b10; baud_div = 9'd1;
    tx_data = 32'hA5A5_A5A5; tx_empty = 1'b0;
    @(negedge clk); tx_empty = 1'b1;
    repeat (7) @(negedge clk);
    #1;
    chk(busy == 1, "R10 busy mid word", busy, 1);
    en = 1'b0;
    @(negedge clk); #1;
    chk(busy == 0, "R6 stop busy", busy, 0);
    chk(sck == 1'b1, "R6 stop sck idle", sck, 1);
    repeat (3) begin
      @(negedge clk); #1;
      chk(sck == 1'b1 && rx_push == 0, "R6 stays stopped", {sck, rx_push}, 2);
    end
    summary();
  end
endmodule